// File: doc/BRIEF.md
# Register FIFO with Single-Cycle Match-Replace

This block is a first-in first-out store built from flip-flops and run as a circular buffer. After reset it is empty. Pushes fill it one word per cycle until it holds `DEPTH` words. From then on it stays full, and every push evicts the oldest word. The evicted word is presented on a registered read port together with a one-cycle valid pulse.

Any push may also carry a search-and-replace request. Every entry has its own equality comparator and a select between holding its value and loading the change value. In the clock edge that takes the push, every stored word equal to the compare value becomes the change value, whatever the depth. The word being pushed is stored exactly as presented. The word being evicted leaves with the value it held before the replacement.

The width and the depth are parameters. The depth must be a power of two of at least 2, so that the pointers wrap without extra logic.

Top module: `mrf_fifo`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `count` = 0, `full` = 0 and `rd_valid` = 0. Any push presented during reset is discarded.
- R2: A push while `full` is 0 raises `count` by one on that edge and produces no eviction: `rd_valid` stays 0 in the following cycle.
- R3: `full` is 1 exactly when `count` equals `DEPTH`. Once set it stays set until reset, and `count` never exceeds `DEPTH`.
- R4: A push while `full` is 1 drives `rd_valid` to 1 for the following cycle, with `rd_data` holding the oldest stored word. Words leave in the order they were pushed. `rd_data` holds its value between evictions.
- R5: A push with `rep_en` = 1 replaces every stored word equal to `rep_cmp` with `rep_chg` in that same clock edge. Words that do not match are untouched.
- R6: The word evicted by a push leaves with the value it held before that cycle's replacement, even when it matches `rep_cmp`.
- R7: The pushed word is stored exactly as given on `wr_data`, even when it equals `rep_cmp`.
- R8: `rep_en` without `push` has no effect: no stored word changes, and `count`, `full` and `rd_valid` behave as in an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Insert `wr_data` this cycle |
| wr_data | input | WIDTH | Word to insert |
| rep_en | input | 1 | Request match-replace together with the push |
| rep_cmp | input | WIDTH | Value to search for |
| rep_chg | input | WIDTH | Value written into every matching entry |
| rd_data | output | WIDTH | Most recently evicted word |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` was just evicted |
| full | output | 1 | Buffer holds DEPTH words |
| count | output | $clog2(DEPTH)+1 | Number of stored words |

## Verification
The bench builds the block with WIDTH = 8 and DEPTH = 4. With a depth this small, the fill-to-full transition, pointer wrap-around and several full rotations of the buffer all occur within a few dozen pushes. This lets every replaced word be drained back out through the eviction port and compared. The sequences include a replacement that hits two entries at once, one that matches the word being evicted, one that matches the word being pushed, and a replace request without a push, whose effect is checked when the affected words come out.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

    // Fill phase of the buffer
    typedef enum logic {
        PH_FILL = 1'b0,
        PH_FULL = 1'b1
    } phase_e;

    // Per-entry next-value selection
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_SWAP = 2'd2
    } act_e;

    function automatic bit is_pow2(input int n);
        return (n >= 2) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/mrf_entry.sv
module mrf_entry #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    input  logic             rep_go,
    input  logic [WIDTH-1:0] cmp,
    input  logic [WIDTH-1:0] chg,
    output logic [WIDTH-1:0] q
);
    import mrf_pkg::*;

    act_e act;

    always_comb begin
        if (load)                      act = ACT_LOAD;
        else if (rep_go && (q == cmp)) act = ACT_SWAP;
        else                           act = ACT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: q <= din;
                ACT_SWAP: q <= chg;
                default:  q <= q;
            endcase
        end
    end

    // R7: the new word lands unaltered
    p_load_exact_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(din)));

    // R5: a matching entry takes the change value
    p_replace_hit_r5: assert property (@(posedge clk) disable iff (rst)
        (rep_go && !load && (q == cmp)) |=> (q == $past(chg)));

    // R5: a non-matching entry is untouched
    p_replace_miss_r5: assert property (@(posedge clk) disable iff (rst)
        (rep_go && !load && (q != cmp)) |=> $stable(q));

    // R8: nothing moves without a push
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && !rep_go) |=> $stable(q));

endmodule

// File: rtl/mrf_ptr_ctrl.sv
module mrf_ptr_ctrl #(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          full
);
    import mrf_pkg::*;

    localparam logic [CW-1:0] LAST_FILL = CW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP       = CW'(DEPTH);

    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            phase  <= PH_FILL;
        end else if (push) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (phase == PH_FULL) begin
                rd_ptr <= rd_ptr + 1'b1;
            end else begin
                count <= count + 1'b1;
                if (count == LAST_FILL) phase <= PH_FULL;
            end
        end
    end

    assign full = (phase == PH_FULL);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CAP);

    p_full_matches_count_r3: assert property (@(posedge clk) disable iff (rst)
        full == (count == CAP));

    p_full_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        full |=> full);

    p_fill_step_r2: assert property (@(posedge clk) disable iff (rst)
        (push && !full) |=> (count == $past(count) + 1'b1));

    // R4: when full, the oldest slot is also the next write slot
    p_ptrs_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        full |-> (rd_ptr == wr_ptr));

endmodule

// File: rtl/mrf_fifo.sv
module mrf_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rep_en,
    input  logic [WIDTH-1:0] rep_cmp,
    input  logic [WIDTH-1:0] rep_chg,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             full,
    output logic [CW-1:0]    count
);
    import mrf_pkg::*;

    initial begin : p_depth_pow2
        assert (is_pow2(DEPTH)) else $error("DEPTH must be a power of two >= 2");
    end

    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [WIDTH-1:0] stor [DEPTH];
    logic             rep_go;

    // Replacement only rides along with a push (R8)
    assign rep_go = push && rep_en;

    mrf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .push   (push),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .count  (count),
        .full   (full)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic load_i;
        assign load_i = push && (wr_ptr == PW'(i));
        mrf_entry #(.WIDTH(WIDTH)) u_ent (
            .clk    (clk),
            .rst    (rst),
            .load   (load_i),
            .din    (wr_data),
            .rep_go (rep_go),
            .cmp    (rep_cmp),
            .chg    (rep_chg),
            .q      (stor[i])
        );
    end

    // Eviction port: value captured before this edge's replacement (R6)
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= push && full;
            if (push && full) rd_data <= stor[rd_ptr];
        end
    end

    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && !full && !rd_valid));

    p_no_evict_fill_r2: assert property (@(posedge clk) disable iff (rst)
        (push && !full) |=> !rd_valid);

    p_evict_on_full_r4: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> rd_valid);

    p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(push && full) |=> $stable(rd_data));

    p_ignore_lone_rep_r8: assert property (@(posedge clk) disable iff (rst)
        (rep_en && !push) |=> ($stable(count) && !rd_valid));

endmodule

// File: tb/tb_mrf_fifo.sv
`timescale 1ns/1ps
module tb_mrf_fifo;
    localparam int WIDTH = 8;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic       push;
        logic       rep;
        logic [7:0] data;
        logic [7:0] cmp;
        logic [7:0] chg;
        logic       ev;
        logic [7:0] evd;
        logic [2:0] cnt;
    } vec_t;

    // Store order after each row is noted at the right (oldest first)
    localparam int NV = 14;
    localparam vec_t TAB [NV] = '{
        '{1'b1, 1'b0, 8'h11, 8'h00, 8'h00, 1'b0, 8'h00, 3'd1}, // 11
        '{1'b1, 1'b0, 8'h22, 8'h00, 8'h00, 1'b0, 8'h00, 3'd2}, // 11 22
        '{1'b1, 1'b0, 8'h11, 8'h00, 8'h00, 1'b0, 8'h00, 3'd3}, // 11 22 11
        '{1'b1, 1'b0, 8'h33, 8'h00, 8'h00, 1'b0, 8'h00, 3'd4}, // 11 22 11 33
        '{1'b1, 1'b1, 8'h44, 8'h11, 8'h55, 1'b1, 8'h11, 3'd4}, // 22 55 33 44
        '{1'b0, 1'b1, 8'h00, 8'h22, 8'h99, 1'b0, 8'h11, 3'd4}, // ignored
        '{1'b1, 1'b1, 8'h66, 8'h66, 8'h77, 1'b1, 8'h22, 3'd4}, // 55 33 44 66
        '{1'b1, 1'b1, 8'h66, 8'h55, 8'h88, 1'b1, 8'h55, 3'd4}, // 33 44 66 66
        '{1'b1, 1'b1, 8'h01, 8'h66, 8'h02, 1'b1, 8'h33, 3'd4}, // 44 02 02 01
        '{1'b1, 1'b0, 8'h03, 8'h00, 8'h00, 1'b1, 8'h44, 3'd4},
        '{1'b1, 1'b0, 8'h04, 8'h00, 8'h00, 1'b1, 8'h02, 3'd4},
        '{1'b1, 1'b0, 8'h05, 8'h00, 8'h00, 1'b1, 8'h02, 3'd4},
        '{1'b1, 1'b0, 8'h06, 8'h00, 8'h00, 1'b1, 8'h01, 3'd4},
        '{1'b1, 1'b0, 8'h07, 8'h00, 8'h00, 1'b1, 8'h03, 3'd4}
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             push;
    logic [WIDTH-1:0] wr_data;
    logic             rep_en;
    logic [WIDTH-1:0] rep_cmp;
    logic [WIDTH-1:0] rep_chg;
    logic [WIDTH-1:0] rd_data;
    logic             rd_valid;
    logic             full;
    logic [CW-1:0]    count;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mrf_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .push(push), .wr_data(wr_data),
        .rep_en(rep_en), .rep_cmp(rep_cmp), .rep_chg(rep_chg),
        .rd_data(rd_data), .rd_valid(rd_valid), .full(full), .count(count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic step(input logic p, input logic r, input logic [7:0] d,
                        input logic [7:0] c, input logic [7:0] g);
        push = p; rep_en = r; wr_data = d; rep_cmp = c; rep_chg = g;
        @(negedge clk);
    endtask

    function automatic string row_tag(input int k);
        case (k)
            0, 1, 2: return "R2 fill";
            3:       return "R3 reaches full";
            4:       return "R6 evict pre-replace";
            5:       return "R8 lone replace";
            6:       return "R7 push not replaced";
            7:       return "R6 evict matching cmp";
            8:       return "R5 double hit";
            default: return "R4 drain order";
        endcase
    endfunction

    task automatic check_idle_reset();
        chk("R1 count", int'(count), 0);
        chk("R1 full", int'(full), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        rst = 1'b1; push = 1'b0; rep_en = 1'b0;
        wr_data = '0; rep_cmp = '0; rep_chg = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_idle_reset();

        for (int k = 0; k < NV; k++) begin
            step(TAB[k].push, TAB[k].rep, TAB[k].data, TAB[k].cmp, TAB[k].chg);
            chk({row_tag(k), " rd_valid"}, int'(rd_valid), int'(TAB[k].ev));
            chk({row_tag(k), " rd_data"},  int'(rd_data),  int'(TAB[k].evd));
            chk({row_tag(k), " count R3"}, int'(count),    int'(TAB[k].cnt));
            chk({row_tag(k), " full R3"},  int'(full),     int'(TAB[k].cnt == 3'd4));
        end

        // Idle while full: no eviction, rd_data held (R4)
        step(1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
        chk("R4 idle no pulse", int'(rd_valid), 0);
        chk("R4 idle hold", int'(rd_data), 8'h03);
        chk("R3 full sticky", int'(full), 1);

        // Reset while full, with a push presented (R1)
        rst = 1'b1;
        step(1'b1, 1'b1, 8'hAB, 8'h04, 8'hCD);
        rst = 1'b0;
        check_idle_reset();
        chk("R1 rd_data cleared", int'(rd_data), 0);

        // Refill after reset, replacement during partial fill (R5, R2)
        step(1'b1, 1'b0, 8'h00, 8'h00, 8'h00);
        chk("R2 count after reset", int'(count), 1);
        step(1'b1, 1'b1, 8'hAA, 8'h00, 8'hBB);
        chk("R2 no evict partial", int'(rd_valid), 0);
        step(1'b1, 1'b0, 8'hCC, 8'h00, 8'h00);
        step(1'b1, 1'b0, 8'hDD, 8'h00, 8'h00);
        chk("R3 full again", int'(full), 1);
        step(1'b1, 1'b0, 8'hEE, 8'h00, 8'h00);
        chk("R5 partial-fill replace", int'(rd_data), 8'hBB);
        chk("R4 pulse after refill", int'(rd_valid), 1);
        step(1'b1, 1'b0, 8'hEF, 8'h00, 8'h00);
        chk("R4 second after refill", int'(rd_data), 8'hAA);
        step(1'b0, 1'b0, 8'h00, 8'h00, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule